// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic engine beside a microcontroller's accumulator. On a one-cycle `start` pulse it captures the accumulator value, a second operand, the B register, the incoming carry and auxiliary-carry bits, and a 5-bit operation code. It then presents a new accumulator value, a new B value where the operation produces one, and new carry (C), auxiliary-carry (AC) and overflow (OV) bits. Each of the five results comes with its own write strobe, so the surrounding register file only updates what the operation actually changes.

Most operations finish in one clock. Multiply and divide run through a shared shift-and-add / restoring-subtract engine, one bit per clock. A small controller sequences the work through four states. ST_IDLE waits for `start`. In ST_IDLE, a multiply or a divide by a nonzero divisor takes the transition *launch* to ST_ITER. Every other operation, including a divide by zero, takes *direct* to ST_FIN with its result already registered. ST_ITER performs one engine step per clock and takes *last step* to ST_PACK once eight steps are done; until then it *iterates* in place. ST_PACK moves the engine result into the output registers and takes *pack* to ST_FIN. ST_FIN asserts `done` for one cycle and takes *retire* back to ST_IDLE.

Top module: `acc_alu`

## Requirements
- R1: After reset, `busy`, `done`, all five write strobes and all data/flag outputs are 0.
- R2: ADD (op 0) computes A+operand and ADDC (op 1) computes A+operand+cy_in. Both write A, C, AC and OV. C is the carry out of bit 7, AC the carry out of bit 3, and OV is set when exactly one of the carries out of bits 6 and 7 occurs.
- R3: SUBB (op 2) computes A-operand-cy_in and writes A, C (borrow out of bit 7), AC (borrow out of bit 3) and OV (signed overflow).
- R4: INC (op 3) and DEC (op 4) write only A, wrapping modulo 256. No flag strobe is raised.
- R5: MUL (op 5) writes the low product byte to A and the high byte to B. It clears C and sets OV exactly when the product exceeds FFh; AC is not written.
- R6: DIV (op 6) with a nonzero B writes the quotient A/B to A and the remainder to B, and writes C=0 and OV=0.
- R7: DIV with B=0 raises neither the A nor the B strobe. It writes C=0 and OV=1.
- R8: DA (op 7) adds 06h when the low nibble exceeds 9 or ac_in is set. It then adds 60h when the high nibble exceeds 9 or a carry is present, and in that case sets C. It writes A and C only.
- R9: ANL (op 8), ORL (op 9), XRL (op 10), CPL (op 11, inverts A) and CLR (op 12, A=0) write only A.
- R10: RL (op 13) and RR (op 15) rotate A by one bit and write only A. RLC (op 14) and RRC (op 16) rotate through C as a ninth bit and write A and C.
- R11: SWAP (op 17) exchanges the two nibbles of A and writes only A.
- R12: `done` is a single-cycle pulse. It arrives 1 clock after the accepting edge for single-cycle operations and for divide by zero, and 10 clocks after it for MUL and for DIV with nonzero B. `busy` is high from acceptance until `done` ends, and `start` is ignored while `busy` is high.
- R13: Op codes 18 to 31 still produce `done` after 1 clock, with all five write strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation (ignored while busy) |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand for add, subtract and bitwise ops |
| breg_in | input | 8 | B register (multiplier or divisor) |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| acc_out | output | 8 | New accumulator value |
| breg_out | output | 8 | New B value |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| wr_acc | output | 1 | Write strobe for A, valid with done |
| wr_breg | output | 1 | Write strobe for B, valid with done |
| wr_cy | output | 1 | Write strobe for C, valid with done |
| wr_ac | output | 1 | Write strobe for AC, valid with done |
| wr_ov | output | 1 | Write strobe for OV, valid with done |

## Verification
Results and strobes of single-cycle operations and of a zero-divisor divide are due in the cycle after the edge that samples `start`. Multiply and nonzero divide deliver theirs ten edges later, after eight engine steps and one packing cycle. The bench drives `start` on a falling edge and counts falling edges until `done` appears. It compares that count with the expected latency of 1 or 10, then reads every result in that same `done` cycle. Values are compared only where the matching strobe is expected high; the strobe pattern itself is always compared.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_MUL  = 5'd5,
        OP_DIV  = 5'd6,
        OP_DA   = 5'd7,
        OP_ANL  = 5'd8,
        OP_ORL  = 5'd9,
        OP_XRL  = 5'd10,
        OP_CPL  = 5'd11,
        OP_CLR  = 5'd12,
        OP_RL   = 5'd13,
        OP_RLC  = 5'd14,
        OP_RR   = 5'd15,
        OP_RRC  = 5'd16,
        OP_SWAP = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_PACK,
        ST_FIN
    } alu_state_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          c;
        logic          ac;
        logic          ov;
        logic          wa;
        logic          wb;
        logic          wc;
        logic          wac;
        logic          wov;
    } alu_res_t;

    function automatic logic is_arith(input logic [OPW-1:0] code);
        return (code <= OP_DEC) || (code == OP_DA);
    endfunction

    function automatic logic is_bitop(input logic [OPW-1:0] code);
        return (code >= OP_ANL) && (code <= OP_SWAP);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   o,
    input  logic           cy,
    input  logic           ac,
    output alu_res_t       res
);
    localparam int H = W / 2;
    localparam logic [W-1:0] LO_FIX = W'(6);
    localparam logic [W-1:0] HI_FIX = LO_FIX << H;
    localparam logic [H-1:0] BCD_MAX = H'(9);

    logic [W:0] sum, dif, t1, t2;
    logic       cin, c1;

    always_comb begin
        cin = (op == OP_ADDC) ? cy : 1'b0;
        sum = {1'b0, a} + {1'b0, o} + (W+1)'(cin);
        dif = {1'b0, a} - {1'b0, o} - (W+1)'(cy);
        // low-nibble correction, then high-nibble correction
        t1  = {1'b0, a} + {1'b0, ((a[H-1:0] > BCD_MAX) || ac) ? LO_FIX : {W{1'b0}}};
        c1  = cy | t1[W];
        t2  = {1'b0, t1[W-1:0]} +
              {1'b0, ((t1[W-1:H] > BCD_MAX) || c1) ? HI_FIX : {W{1'b0}}};
    end

    always_comb begin
        res = '0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res.a   = sum[W-1:0];
                res.c   = sum[W];
                res.ac  = sum[H] ^ a[H] ^ o[H];
                res.ov  = (sum[W-1] ^ a[W-1] ^ o[W-1]) ^ sum[W];
                res.wa  = 1'b1;
                res.wc  = 1'b1;
                res.wac = 1'b1;
                res.wov = 1'b1;
            end
            OP_SUBB: begin
                res.a   = dif[W-1:0];
                res.c   = dif[W];
                res.ac  = dif[H] ^ a[H] ^ o[H];
                res.ov  = (a[W-1] ^ o[W-1]) & (dif[W-1] ^ a[W-1]);
                res.wa  = 1'b1;
                res.wc  = 1'b1;
                res.wac = 1'b1;
                res.wov = 1'b1;
            end
            OP_INC: begin
                res.a  = a + W'(1);
                res.wa = 1'b1;
            end
            OP_DEC: begin
                res.a  = a - W'(1);
                res.wa = 1'b1;
            end
            OP_DA: begin
                res.a  = t2[W-1:0];
                res.c  = c1 | t2[W];
                res.wa = 1'b1;
                res.wc = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   o,
    input  logic           cy,
    output alu_res_t       res
);
    localparam int H = W / 2;

    always_comb begin
        res    = '0;
        res.wa = 1'b1;
        unique case (op)
            OP_ANL:  res.a = a & o;
            OP_ORL:  res.a = a | o;
            OP_XRL:  res.a = a ^ o;
            OP_CPL:  res.a = ~a;
            OP_CLR:  res.a = '0;
            OP_RL:   res.a = {a[W-2:0], a[W-1]};
            OP_RR:   res.a = {a[0], a[W-1:1]};
            OP_RLC: begin
                res.a  = {a[W-2:0], cy};
                res.c  = a[W-1];
                res.wc = 1'b1;
            end
            OP_RRC: begin
                res.a  = {cy, a[W-1:1]};
                res.c  = a[0];
                res.wc = 1'b1;
            end
            OP_SWAP: res.a = {a[H-1:0], a[W-1:H]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         is_div,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic [2*W-1:0] p;
    logic [W-1:0]   m;
    logic [W:0]     sum, trial;
    logic [W-1:0]   diff;
    logic           ge;

    always_comb begin
        sum   = {1'b0, p[2*W-1:W]} + {1'b0, p[0] ? m : {W{1'b0}}};
        trial = {p[2*W-1:W], p[W-1]};
        ge    = trial >= {1'b0, m};
        diff  = trial[W-1:0] - m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p <= '0;
            m <= '0;
        end else if (load) begin
            p <= {{W{1'b0}}, a};
            m <= b;
        end else if (step) begin
            if (is_div)
                p <= {(ge ? diff : trial[W-1:0]), p[W-2:0], ge};
            else
                p <= {sum, p[W-1:1]};
        end
    end

    assign lo = p[W-1:0];
    assign hi = p[2*W-1:W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   acc_in,
    input  logic [W-1:0]   opnd_in,
    input  logic [W-1:0]   breg_in,
    input  logic           cy_in,
    input  logic           ac_in,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   acc_out,
    output logic [W-1:0]   breg_out,
    output logic           cy_out,
    output logic           ac_out,
    output logic           ov_out,
    output logic           wr_acc,
    output logic           wr_breg,
    output logic           wr_cy,
    output logic           wr_ac,
    output logic           wr_ov
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    alu_state_e state, nxt;
    alu_res_t   arith_res, bit_res, one_res, out_q;
    logic [CW-1:0] cnt;
    logic          div_q;
    logic          long_op, launch;
    logic [W-1:0]  md_lo, md_hi;

    assign long_op = (op == OP_MUL) || ((op == OP_DIV) && (breg_in != '0));
    assign launch  = (state == ST_IDLE) && start && long_op;

    acc_alu_arith #(.W(W)) u_arith (
        .op(op), .a(acc_in), .o(opnd_in), .cy(cy_in), .ac(ac_in), .res(arith_res)
    );

    acc_alu_bitops #(.W(W)) u_bitops (
        .op(op), .a(acc_in), .o(opnd_in), .cy(cy_in), .res(bit_res)
    );

    acc_alu_muldiv #(.W(W)) u_muldiv (
        .clk(clk), .rst_n(rst_n), .load(launch), .step(state == ST_ITER),
        .is_div(div_q), .a(acc_in), .b(breg_in), .lo(md_lo), .hi(md_hi)
    );

    // single-cycle result selection (includes zero-divisor divide)
    always_comb begin
        one_res = '0;
        if (is_arith(op))
            one_res = arith_res;
        else if (is_bitop(op))
            one_res = bit_res;
        else if (op == OP_DIV) begin
            one_res.a   = acc_in;
            one_res.b   = breg_in;
            one_res.ov  = 1'b1;
            one_res.wc  = 1'b1;
            one_res.wov = 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = long_op ? ST_ITER : ST_FIN;
            ST_ITER: if (cnt == '0) nxt = ST_PACK;
            ST_PACK: nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // step counter and operation memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (launch) begin
            cnt   <= CW'(W - 1);
            div_q <= (op == OP_DIV);
        end else if (state == ST_ITER && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start && !long_op) out_q <= one_res;
                ST_PACK: begin
                    out_q.a   <= md_lo;
                    out_q.b   <= md_hi;
                    out_q.c   <= 1'b0;
                    out_q.ov  <= div_q ? 1'b0 : (md_hi != '0);
                    out_q.wa  <= 1'b1;
                    out_q.wb  <= 1'b1;
                    out_q.wc  <= 1'b1;
                    out_q.wac <= 1'b0;
                    out_q.wov <= 1'b1;
                end
                ST_FIN: begin
                    out_q.wa  <= 1'b0;
                    out_q.wb  <= 1'b0;
                    out_q.wc  <= 1'b0;
                    out_q.wac <= 1'b0;
                    out_q.wov <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign acc_out  = out_q.a;
    assign breg_out = out_q.b;
    assign cy_out   = out_q.c;
    assign ac_out   = out_q.ac;
    assign ov_out   = out_q.ov;
    assign wr_acc   = out_q.wa;
    assign wr_breg  = out_q.wb;
    assign wr_cy    = out_q.wc;
    assign wr_ac    = out_q.wac;
    assign wr_ov    = out_q.wov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         wr_acc,
    input logic         wr_breg,
    input logic         wr_cy,
    input logic         wr_ac,
    input logic         wr_ov,
    input logic         cy_out,
    input logic         ov_out,
    input logic [W-1:0] breg_out
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R12
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc || wr_breg || wr_cy || wr_ac || wr_ov) |-> done);

    // R2
    ac_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ac |-> (wr_cy && wr_ov && wr_acc && !wr_breg));

    // R6
    ab_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_breg |-> (wr_acc && wr_cy && !cy_out));

    // R5
    mul_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_breg && ov_out) |-> (breg_out != '0));

    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ov && !wr_acc) |-> (ov_out && wr_cy && !cy_out));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, breg_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0;
    logic       busy, done, cy_out, ac_out, ov_out;
    logic       wr_acc, wr_breg, wr_cy, wr_ac, wr_ov;
    logic [7:0] acc_out, breg_out;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .acc_in(acc_in), .opnd_in(opnd_in), .breg_in(breg_in),
        .cy_in(cy_in), .ac_in(ac_in), .busy(busy), .done(done),
        .acc_out(acc_out), .breg_out(breg_out), .cy_out(cy_out),
        .ac_out(ac_out), .ov_out(ov_out), .wr_acc(wr_acc),
        .wr_breg(wr_breg), .wr_cy(wr_cy), .wr_ac(wr_ac), .wr_ov(wr_ov)
    );

    // {op, a, opnd, b, cy, ac, expA, expB, strobes{A,B,C,AC,OV}, expC, expAC, expOV}
    localparam int NV = 29;
    localparam logic [54:0] VEC [NV] = '{
        {5'd0,  8'h3F, 8'hD3, 8'h00, 1'b1, 1'b0, 8'h12, 8'h00, 5'h17, 1'b1, 1'b1, 1'b0},
        {5'd0,  8'h7F, 8'h73, 8'h00, 1'b0, 1'b0, 8'hF2, 8'h00, 5'h17, 1'b0, 1'b1, 1'b1},
        {5'd1,  8'h8F, 8'hD3, 8'h00, 1'b1, 1'b0, 8'h63, 8'h00, 5'h17, 1'b1, 1'b1, 1'b1},
        {5'd1,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h01, 8'h00, 5'h17, 1'b0, 1'b0, 1'b0},
        {5'd2,  8'h49, 8'h21, 8'h00, 1'b1, 1'b0, 8'h27, 8'h00, 5'h17, 1'b0, 1'b0, 1'b0},
        {5'd2,  8'h10, 8'h20, 8'h00, 1'b0, 1'b0, 8'hF0, 8'h00, 5'h17, 1'b1, 1'b0, 1'b0},
        {5'd2,  8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 8'h7F, 8'h00, 5'h17, 1'b0, 1'b1, 1'b1},
        {5'd2,  8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 5'h17, 1'b1, 1'b1, 1'b0},
        {5'd3,  8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd4,  8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd5,  8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h01, 8'hFE, 5'h1D, 1'b0, 1'b0, 1'b1},
        {5'd5,  8'h0C, 8'h00, 8'h0A, 1'b1, 1'b0, 8'h78, 8'h00, 5'h1D, 1'b0, 1'b0, 1'b0},
        {5'd6,  8'hFB, 8'h00, 8'h12, 1'b1, 1'b0, 8'h0D, 8'h11, 5'h1D, 1'b0, 1'b0, 1'b0},
        {5'd6,  8'h05, 8'h00, 8'h07, 1'b1, 1'b0, 8'h00, 8'h05, 5'h1D, 1'b0, 1'b0, 1'b0},
        {5'd6,  8'h37, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 5'h05, 1'b0, 1'b0, 1'b1},
        {5'd7,  8'h4C, 8'h00, 8'h00, 1'b0, 1'b0, 8'h52, 8'h00, 5'h14, 1'b0, 1'b0, 1'b0},
        {5'd7,  8'h9A, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 5'h14, 1'b1, 1'b0, 1'b0},
        {5'd7,  8'h21, 8'h00, 8'h00, 1'b1, 1'b1, 8'h87, 8'h00, 5'h14, 1'b1, 1'b0, 1'b0},
        {5'd8,  8'hAC, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h0C, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd9,  8'hAC, 8'h0F, 8'h00, 1'b1, 1'b1, 8'hAF, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd10, 8'hAC, 8'h0F, 8'h00, 1'b1, 1'b1, 8'hA3, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd11, 8'hAC, 8'h00, 8'h00, 1'b1, 1'b1, 8'h53, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd12, 8'hAC, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd13, 8'hF0, 8'h00, 8'h00, 1'b1, 1'b0, 8'hE1, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd15, 8'hF0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h78, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd16, 8'hBD, 8'h00, 8'h00, 1'b0, 1'b0, 8'h5E, 8'h00, 5'h14, 1'b1, 1'b0, 1'b0},
        {5'd14, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0, 8'h79, 8'h00, 5'h14, 1'b0, 1'b0, 1'b0},
        {5'd17, 8'h72, 8'h00, 8'h00, 1'b1, 1'b1, 8'h27, 8'h00, 5'h10, 1'b0, 1'b0, 1'b0},
        {5'd18, 8'h55, 8'h33, 8'h11, 1'b1, 1'b1, 8'h00, 8'h00, 5'h00, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] code, input logic [7:0] bv);
        case (code)
            5'd0, 5'd1:                  return "R2";
            5'd2:                        return "R3";
            5'd3, 5'd4:                  return "R4";
            5'd5:                        return "R5";
            5'd6:                        return (bv == 8'h00) ? "R7" : "R6";
            5'd7:                        return "R8";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R9";
            5'd13, 5'd14, 5'd15, 5'd16:  return "R10";
            5'd17:                       return "R11";
            default:                     return "R13";
        endcase
    endfunction

    task automatic run_op(input logic [4:0] code, input logic [7:0] a, input logic [7:0] o,
                          input logic [7:0] bv, input logic c, input logic h, output int lat);
        @(negedge clk);
        op = code; acc_in = a; opnd_in = o; breg_in = bv; cy_in = c; ac_in = h;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        int lat;
        int dones;
        logic [54:0] v;
        string tg;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy/done", {30'd0, busy, done}, 32'd0);
        chk("R1 strobes", {27'd0, wr_acc, wr_breg, wr_cy, wr_ac, wr_ov}, 32'd0);
        chk("R1 data", {13'd0, acc_out, breg_out, cy_out, ac_out, ov_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {31'd0, busy}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            v  = VEC[i];
            tg = tag_of(v[54:50], v[33:26]);
            run_op(v[54:50], v[49:42], v[41:34], v[33:26], v[25], v[24], lat);
            chk({tg, " R12 latency"}, lat,
                ((v[54:50] == 5'd5) || (v[54:50] == 5'd6 && v[33:26] != 8'h00)) ? 10 : 1);
            chk({tg, " strobes"}, {27'd0, wr_acc, wr_breg, wr_cy, wr_ac, wr_ov}, {27'd0, v[7:3]});
            if (v[7]) chk({tg, " A"}, {24'd0, acc_out}, {24'd0, v[23:16]});
            if (v[6]) chk({tg, " B"}, {24'd0, breg_out}, {24'd0, v[15:8]});
            if (v[5]) chk({tg, " C"}, {31'd0, cy_out}, {31'd0, v[2]});
            if (v[4]) chk({tg, " AC"}, {31'd0, ac_out}, {31'd0, v[1]});
            if (v[3]) chk({tg, " OV"}, {31'd0, ov_out}, {31'd0, v[0]});
        end

        // R12: busy during multiply, start ignored while busy, single done pulse
        @(negedge clk);
        op = 5'd5; acc_in = 8'h0C; breg_in = 8'h0A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 busy after accept", {31'd0, busy}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        op = 5'd12; acc_in = 8'hAA; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int k = 0; k < 20; k++) begin
            if (done) begin
                dones++;
                chk("R12 in-flight result kept", {24'd0, acc_out}, 32'h78);
                chk("R12 in-flight strobes", {27'd0, wr_acc, wr_breg, wr_cy, wr_ac, wr_ov}, 32'h1D);
            end
            @(negedge clk);
        end
        chk("R12 one done only", dones, 1);
        chk("R12 idle afterwards", {31'd0, busy}, 32'd0);

        // R12: done is one cycle wide, strobes drop with it
        run_op(5'd17, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b0, lat);
        chk("R11 swap", {24'd0, acc_out}, 32'hA5);
        @(negedge clk);
        chk("R12 done drops", {31'd0, done}, 32'd0);
        chk("R12 strobes drop", {27'd0, wr_acc, wr_breg, wr_cy, wr_ac, wr_ov}, 32'd0);

        // R5: product exactly FFh leaves OV clear
        run_op(5'd5, 8'h11, 8'h00, 8'h0F, 1'b0, 1'b0, lat);
        chk("R5 FFh product A", {24'd0, acc_out}, 32'hFF);
        chk("R5 FFh product OV", {31'd0, ov_out}, 32'd0);

        // R6: divide by one
        run_op(5'd6, 8'hC3, 8'h00, 8'h01, 1'b1, 1'b0, lat);
        chk("R6 div by one", {16'd0, acc_out, breg_out}, 32'hC300);

        summary();
        $finish;
    end
endmodule